// File: doc/BRIEF.md
# Per-CPU Interrupt Selection Core

This block sits at the centre of a small multi-processor interrupt controller. For every interrupt ID it keeps an enable bit, a pending bit for each CPU, and an 8-bit priority. IDs 0 to 31 have a separate priority for each CPU. IDs 32 and above have one priority that all CPUs share. For each external line it also keeps a trigger-style bit (edge or level), a CPU target mask and the last sampled input level. External line `n` becomes interrupt ID `n+32`.

For each CPU, a comparator tree scans all interrupts. It picks the most urgent one that is both enabled and pending for that CPU. The pick then passes through the CPU's priority mask and is compared with the priority that CPU is running at. The results are registered as one request line and one current-pending ID per CPU, and 1023 means "nothing". Register programming, acknowledge and completion happen outside the block. They reach it as single-cycle strobes, a per-CPU mask value and a per-CPU running priority.

Top module: `irq_select_core`

## Requirements
- R1: Reset empties all state: no enables, no pending bits, no stored levels, all priorities 0. Every `irq_req` bit is 0 and every `cur_id` field is 1023.
- R2: An interrupt is a candidate for CPU c only when its enable bit is set and its pending bit for c is set. A pending but disabled interrupt is never reported.
- R3: A numerically lower priority is more urgent, and the search starts from priority 0x100. When priorities are equal, the lower ID wins.
- R4: The chosen ID appears on `cur_id` for CPU c only if its priority is less than or equal to `pmask` for c. Otherwise `cur_id` is 1023 and the request is 0.
- R5: `irq_req[c]` is 1 only when the chosen priority is strictly below `run_prio` for c. `run_prio` is 9 bits wide, and 0x100 means the CPU is idle.
- R6: If `gbl_en` is 0, or `cpu_if_en[c]` is 0, then CPU c has request 0 and ID 1023.
- R7: A rising level on `ext_lvl[n]` sets the pending bits of ID n+32 for every CPU in that line's target mask. This happens when the line is edge-configured (`cfg_edge`=1), or when it is enabled at that moment.
- R8: A rising level on a level-configured line that is disabled sets no pending bit, and enabling the line later does not make it pending. A falling level only updates the stored level and leaves pending bits as they were.
- R9: `prio_wr` writes the per-CPU priority selected by `prio_cpu` for IDs below 32. For IDs 32 and above it writes the shared priority and ignores `prio_cpu`.
- R10: `pend_set` and `pend_clr` act on ID `pend_id` for the CPUs in `pend_mask` (bit c = CPU c). When both are given in the same cycle, the clear wins.
- R11: A state change made at clock edge k shows on `irq_req` and `cur_id` after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gbl_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NCPU | Per-CPU interface enable |
| cfg_wr | input | 1 | Strobe: write enable/trigger/target for `cfg_id` |
| cfg_id | input | 10 | Interrupt ID for the configuration write |
| cfg_en | input | 1 | Enable value to store |
| cfg_edge | input | 1 | 1 = edge-configured (IDs 32 and above only) |
| cfg_tgt | input | NCPU | CPU target mask (IDs 32 and above only) |
| prio_wr | input | 1 | Strobe: write a priority |
| prio_id | input | 10 | Interrupt ID for the priority write |
| prio_cpu | input | CPU_IDX_W | CPU bank selected for IDs below 32 |
| prio_val | input | 8 | Priority value |
| pend_set | input | 1 | Strobe: set pending bits |
| pend_clr | input | 1 | Strobe: clear pending bits |
| pend_id | input | 10 | Interrupt ID for the pending update |
| pend_mask | input | NCPU | CPUs affected by the pending update |
| ext_lvl | input | NIRQ-32 | External interrupt levels, synchronous to `clk` |
| pmask | input | NCPU*8 | Per-CPU priority mask, 8 bits per CPU |
| run_prio | input | NCPU*9 | Per-CPU running priority, 0x100 = idle |
| irq_req | output | NCPU | Per-CPU interrupt request |
| cur_id | output | NCPU*10 | Per-CPU current pending ID, 1023 = none |

## Verification
Two situations are hard to reach from the ports. Both involve a pending bit that was set earlier but was invisible until a later, unrelated write.

In the first, an edge-configured line is raised while it is disabled, and the pending bit can only be observed after a configuration write enables it. The mirror case is a level-configured line raised while disabled: it must stay invisible after it is enabled.

The stimulus reaches these cases by separating the edge, the settle cycles and the enabling write. It also chooses the priorities so that the tested ID would win outright if it were pending.

Ties between equal priorities and same-cycle set/clear collisions are produced by writing matching priorities to two pending IDs, and by raising both pending strobes in a single cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int PRIO_W = 8;
  localparam int RANK_W = PRIO_W + 1;
  localparam int IDW    = 10;
  localparam logic [IDW-1:0]    NO_IRQ    = 10'd1023;
  localparam logic [RANK_W-1:0] RANK_NONE = 9'h100;

  // Rank of one interrupt for one CPU: its priority if it may compete, else 0x100
  function automatic logic [RANK_W-1:0] cand_rank(input logic en, input logic pend,
                                                  input logic [PRIO_W-1:0] p);
    return (en && pend) ? {1'b0, p} : RANK_NONE;
  endfunction

  // Right-hand (higher ID) entry wins only when strictly more urgent
  function automatic logic right_wins(input logic [RANK_W-1:0] l, input logic [RANK_W-1:0] r);
    return r < l;
  endfunction

  function automatic logic mask_ok(input logic [RANK_W-1:0] best, input logic [PRIO_W-1:0] m);
    return best <= {1'b0, m};
  endfunction

  function automatic logic preempts(input logic [RANK_W-1:0] best, input logic [RANK_W-1:0] run);
    return best < run;
  endfunction

endpackage

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_sel_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int NIRQ      = 64,
  parameter int CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [IDW-1:0]              cfg_id,
  input  logic                        cfg_en,
  input  logic                        cfg_edge,
  input  logic [NCPU-1:0]             cfg_tgt,
  input  logic                        prio_wr,
  input  logic [IDW-1:0]              prio_id,
  input  logic [CPU_IDX_W-1:0]        prio_cpu,
  input  logic [PRIO_W-1:0]           prio_val,
  input  logic                        pend_set,
  input  logic                        pend_clr,
  input  logic [IDW-1:0]              pend_id,
  input  logic [NCPU-1:0]             pend_mask,
  input  logic [NIRQ-33:0]            ext_lvl,
  output logic [NIRQ-1:0]             en_vec,
  output logic [NCPU*NIRQ-1:0]        pend_flat,
  output logic [NCPU*NIRQ*PRIO_W-1:0] prio_flat,
  output logic [NIRQ-33:0]            ext_rise
);
  localparam int NEXT = NIRQ - 32;
  localparam int NBNK = 32;

  logic [NIRQ-1:0]   en_q;
  logic [NEXT-1:0]   edge_q;
  logic [NEXT-1:0]   lvl_q;
  logic [NCPU-1:0]   tgt_q  [NEXT];
  logic [NCPU-1:0]   pend_q [NIRQ];
  logic [NCPU-1:0]   pend_nx[NIRQ];
  logic [PRIO_W-1:0] bank_q [NCPU][NBNK];
  logic [PRIO_W-1:0] shr_q  [NEXT];

  assign ext_rise = ext_lvl & ~lvl_q;
  assign en_vec   = en_q;

  // Pending update order: external edge, set strobe, then clear strobe (clear wins)
  always_comb begin
    for (int i = 0; i < NIRQ; i++) pend_nx[i] = pend_q[i];
    for (int e = 0; e < NEXT; e++) begin
      if (ext_rise[e] && (edge_q[e] || en_q[e+32]))
        pend_nx[e+32] = pend_nx[e+32] | tgt_q[e];
    end
    for (int i = 0; i < NIRQ; i++) begin
      if (pend_set && pend_id == IDW'(i)) pend_nx[i] = pend_nx[i] | pend_mask;
    end
    for (int i = 0; i < NIRQ; i++) begin
      if (pend_clr && pend_id == IDW'(i)) pend_nx[i] = pend_nx[i] & ~pend_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NIRQ; i++) pend_q[i] <= '0;
      lvl_q <= '0;
    end else begin
      for (int i = 0; i < NIRQ; i++) pend_q[i] <= pend_nx[i];
      lvl_q <= ext_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      for (int e = 0; e < NEXT; e++) tgt_q[e] <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < NIRQ; i++)
        if (cfg_id == IDW'(i)) en_q[i] <= cfg_en;
      for (int e = 0; e < NEXT; e++)
        if (cfg_id == IDW'(e + 32)) begin
          edge_q[e] <= cfg_edge;
          tgt_q[e]  <= cfg_tgt;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++)
        for (int k = 0; k < NBNK; k++) bank_q[c][k] <= '0;
      for (int e = 0; e < NEXT; e++) shr_q[e] <= '0;
    end else if (prio_wr) begin
      for (int c = 0; c < NCPU; c++)
        for (int k = 0; k < NBNK; k++)
          if (prio_cpu == CPU_IDX_W'(c) && prio_id == IDW'(k)) bank_q[c][k] <= prio_val;
      for (int e = 0; e < NEXT; e++)
        if (prio_id == IDW'(e + 32)) shr_q[e] <= prio_val;
    end
  end

  for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
      assign pend_flat[gc*NIRQ + gi] = pend_q[gi][gc];
      if (gi < NBNK) begin : g_bank
        assign prio_flat[(gc*NIRQ + gi)*PRIO_W +: PRIO_W] = bank_q[gc][gi];
      end else begin : g_shared
        assign prio_flat[(gc*NIRQ + gi)*PRIO_W +: PRIO_W] = shr_q[gi-NBNK];
      end
    end
  end

endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import irq_sel_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N*RANK_W-1:0] ranks,
  output logic [RANK_W-1:0]   best_rank,
  output logic [IDW-1:0]      best_id
);
  localparam int LVLS  = (N > 1) ? $clog2(N) : 1;
  localparam int NP    = 1 << LVLS;
  localparam int NODES = 2*NP - 1;

  logic [RANK_W-1:0] nr [NODES];
  logic [IDW-1:0]    ni [NODES];

  // Leaves: heap layout, leaf k at NP-1+k, lower IDs on the left
  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign nr[NP-1+k] = ranks[k*RANK_W +: RANK_W];
      assign ni[NP-1+k] = (ranks[k*RANK_W +: RANK_W] == RANK_NONE) ? NO_IRQ : IDW'(k);
    end else begin : g_pad
      assign nr[NP-1+k] = RANK_NONE;
      assign ni[NP-1+k] = NO_IRQ;
    end
  end

  for (genvar n = 0; n < NP-1; n++) begin : g_node
    logic pick_r;
    assign pick_r = right_wins(nr[2*n+1], nr[2*n+2]);
    assign nr[n]  = pick_r ? nr[2*n+2] : nr[2*n+1];
    assign ni[n]  = pick_r ? ni[2*n+2] : ni[2*n+1];
  end

  assign best_rank = nr[0];
  assign best_id   = ni[0];

endmodule

// File: rtl/cpu_decide.sv
module cpu_decide
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic [RANK_W-1:0] best_rank,
  input  logic [IDW-1:0]    best_id,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [RANK_W-1:0] run_prio,
  output logic              mask_pass,
  output logic              preempt,
  output logic              req_q,
  output logic [IDW-1:0]    id_q
);
  assign mask_pass = mask_ok(best_rank, pmask);
  assign preempt   = preempts(best_rank, run_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      id_q  <= NO_IRQ;
    end else if (!gate || !mask_pass) begin
      req_q <= 1'b0;
      id_q  <= NO_IRQ;
    end else begin
      req_q <= preempt;
      id_q  <= best_id;
    end
  end

endmodule

// File: rtl/irq_select_core.sv
module irq_select_core
  import irq_sel_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int NIRQ      = 64,
  parameter int CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gbl_en,
  input  logic [NCPU-1:0]        cpu_if_en,
  input  logic                   cfg_wr,
  input  logic [9:0]             cfg_id,
  input  logic                   cfg_en,
  input  logic                   cfg_edge,
  input  logic [NCPU-1:0]        cfg_tgt,
  input  logic                   prio_wr,
  input  logic [9:0]             prio_id,
  input  logic [CPU_IDX_W-1:0]   prio_cpu,
  input  logic [7:0]             prio_val,
  input  logic                   pend_set,
  input  logic                   pend_clr,
  input  logic [9:0]             pend_id,
  input  logic [NCPU-1:0]        pend_mask,
  input  logic [NIRQ-33:0]       ext_lvl,
  input  logic [NCPU*8-1:0]      pmask,
  input  logic [NCPU*9-1:0]      run_prio,
  output logic [NCPU-1:0]        irq_req,
  output logic [NCPU*10-1:0]     cur_id
);
  localparam int NEXT = NIRQ - 32;

  logic [NIRQ-1:0]             en_vec;
  logic [NCPU*NIRQ-1:0]        pend_all;
  logic [NCPU*NIRQ*PRIO_W-1:0] prio_all;
  logic [NEXT-1:0]             ext_rise;
  logic [NCPU*RANK_W-1:0]      tree_rank_all;
  logic [NCPU-1:0]             mask_pass_all;
  logic [NCPU-1:0]             preempt_all;

  irq_state_bank #(.NCPU(NCPU), .NIRQ(NIRQ), .CPU_IDX_W(CPU_IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_id    (cfg_id),
    .cfg_en    (cfg_en),
    .cfg_edge  (cfg_edge),
    .cfg_tgt   (cfg_tgt),
    .prio_wr   (prio_wr),
    .prio_id   (prio_id),
    .prio_cpu  (prio_cpu),
    .prio_val  (prio_val),
    .pend_set  (pend_set),
    .pend_clr  (pend_clr),
    .pend_id   (pend_id),
    .pend_mask (pend_mask),
    .ext_lvl   (ext_lvl),
    .en_vec    (en_vec),
    .pend_flat (pend_all),
    .prio_flat (prio_all),
    .ext_rise  (ext_rise)
  );

  for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
    logic [NIRQ*RANK_W-1:0] ranks;
    logic [RANK_W-1:0]      best_rank;
    logic [IDW-1:0]         best_id;

    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_rank
      assign ranks[gi*RANK_W +: RANK_W] =
        cand_rank(en_vec[gi], pend_all[gc*NIRQ + gi],
                  prio_all[(gc*NIRQ + gi)*PRIO_W +: PRIO_W]);
    end

    prio_tree #(.N(NIRQ)) u_tree (
      .ranks     (ranks),
      .best_rank (best_rank),
      .best_id   (best_id)
    );

    assign tree_rank_all[gc*RANK_W +: RANK_W] = best_rank;

    cpu_decide u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate      (gbl_en && cpu_if_en[gc]),
      .best_rank (best_rank),
      .best_id   (best_id),
      .pmask     (pmask[gc*8 +: 8]),
      .run_prio  (run_prio[gc*9 +: 9]),
      .mask_pass (mask_pass_all[gc]),
      .preempt   (preempt_all[gc]),
      .req_q     (irq_req[gc]),
      .id_q      (cur_id[gc*10 +: 10])
    );
  end

endmodule

// File: rtl/irq_select_core_chk.sv
module irq_select_core_chk #(
  parameter int NCPU = 2,
  parameter int NIRQ = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gbl_en,
  input logic [NCPU-1:0]      cpu_if_en,
  input logic [NCPU*8-1:0]    pmask,
  input logic [NCPU*9-1:0]    run_prio,
  input logic [NCPU-1:0]      irq_req,
  input logic [NCPU*10-1:0]   cur_id,
  input logic [NCPU*9-1:0]    tree_rank_all,
  input logic [NCPU*NIRQ-1:0] pend_all,
  input logic                 pend_set,
  input logic [NIRQ-33:0]     ext_rise
);

  // R10 / R7: pending bits grow only through the set strobe or an external rise
  p_pend_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_all) > $countones($past(pend_all))) |-> $past(pend_set || (|ext_rise)));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    p_gate_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(gbl_en && cpu_if_en[c])) |-> (!irq_req[c] && cur_id[c*10 +: 10] == 10'd1023));

    p_req_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> $past(tree_rank_all[c*9 +: 9] < run_prio[c*9 +: 9]));

    p_req_has_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> (cur_id[c*10 +: 10] != 10'd1023));

    p_mask_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_id[c*10 +: 10] != 10'd1023) |-> $past(tree_rank_all[c*9 +: 9] <= {1'b0, pmask[c*8 +: 8]}));
  end

endmodule

bind irq_select_core irq_select_core_chk #(.NCPU(NCPU), .NIRQ(NIRQ)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gbl_en        (gbl_en),
  .cpu_if_en     (cpu_if_en),
  .pmask         (pmask),
  .run_prio      (run_prio),
  .irq_req       (irq_req),
  .cur_id        (cur_id),
  .tree_rank_all (tree_rank_all),
  .pend_all      (pend_all),
  .pend_set      (pend_set),
  .ext_rise      (ext_rise)
);

// File: tb/irq_select_core_test.sv
module irq_select_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 2;
  localparam int NIRQ = 64;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic gbl_en;
  logic [NCPU-1:0] cpu_if_en;
  logic cfg_wr, cfg_en, cfg_edge;
  logic [9:0] cfg_id;
  logic [NCPU-1:0] cfg_tgt;
  logic prio_wr;
  logic [9:0] prio_id;
  logic [0:0] prio_cpu;
  logic [7:0] prio_val;
  logic pend_set, pend_clr;
  logic [9:0] pend_id;
  logic [NCPU-1:0] pend_mask;
  logic [NIRQ-33:0] ext_lvl;
  logic [NCPU*8-1:0] pmask;
  logic [NCPU*9-1:0] run_prio;
  logic [NCPU-1:0] irq_req;
  logic [NCPU*10-1:0] cur_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_select_core #(.NCPU(NCPU), .NIRQ(NIRQ)) uut (.*);

  // op: 0 cfg (val[0]=enable, val[1]=edge, m=target), 1 prio (m=cpu), 2 pend set, 3 pend clear
  typedef struct packed {
    logic [1:0] op;
    logic [9:0] id;
    logic [7:0] val;
    logic [7:0] m;
    logic [9:0] e0;
    logic       r0;
    logic [9:0] e1;
    logic       r1;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{2'd0, 10'd5,  8'h01, 8'h00, 10'd1023, 1'b0, 10'd1023, 1'b0, 4'd2},  // R2 nothing pending
    '{2'd2, 10'd5,  8'h00, 8'h01, 10'd5,    1'b1, 10'd1023, 1'b0, 4'd2},  // R2
    '{2'd2, 10'd9,  8'h00, 8'h02, 10'd5,    1'b1, 10'd1023, 1'b0, 4'd2},  // R2 pending but disabled
    '{2'd0, 10'd9,  8'h01, 8'h00, 10'd5,    1'b1, 10'd9,    1'b1, 4'd2},  // R2 enabling reveals
    '{2'd1, 10'd5,  8'h40, 8'h00, 10'd5,    1'b1, 10'd9,    1'b1, 4'd9},  // R9
    '{2'd2, 10'd9,  8'h00, 8'h01, 10'd9,    1'b1, 10'd9,    1'b1, 4'd3},  // R3 lower value wins
    '{2'd1, 10'd9,  8'h40, 8'h00, 10'd5,    1'b1, 10'd9,    1'b1, 4'd3},  // R3 tie -> lower ID
    '{2'd1, 10'd9,  8'h80, 8'h01, 10'd5,    1'b1, 10'd9,    1'b1, 4'd9},  // R9 cpu1 bank
    '{2'd1, 10'd9,  8'h3F, 8'h00, 10'd9,    1'b1, 10'd9,    1'b1, 4'd3},  // R3
    '{2'd3, 10'd9,  8'h00, 8'h03, 10'd5,    1'b1, 10'd1023, 1'b0, 4'd10}, // R10
    '{2'd0, 10'd40, 8'h01, 8'h02, 10'd5,    1'b1, 10'd1023, 1'b0, 4'd2},
    '{2'd1, 10'd40, 8'h20, 8'h00, 10'd5,    1'b1, 10'd1023, 1'b0, 4'd9},
    '{2'd2, 10'd40, 8'h00, 8'h03, 10'd40,   1'b1, 10'd40,   1'b1, 4'd3},  // R3 / R9 shared
    '{2'd3, 10'd40, 8'h00, 8'h01, 10'd5,    1'b1, 10'd40,   1'b1, 4'd10}, // R10
    '{2'd0, 10'd5,  8'h00, 8'h00, 10'd1023, 1'b0, 10'd40,   1'b1, 4'd2},  // R2 disable
    '{2'd3, 10'd40, 8'h00, 8'h02, 10'd1023, 1'b0, 10'd1023, 1'b0, 4'd10}
  };

  task automatic chk(input string tag, input int cpu, input logic [9:0] eid, input logic ereq);
    logic [9:0] aid;
    logic areq;
    aid  = cur_id[cpu*10 +: 10];
    areq = irq_req[cpu];
    checks++;
    if (aid !== eid || areq !== ereq) begin
      errors++;
      $display("FAIL %s cpu%0d: id=%0d req=%0b expected id=%0d req=%0b", tag, cpu, aid, areq, eid, ereq);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [9:0] id, input logic [7:0] val,
                       input logic [7:0] m);
    @(negedge clk);
    case (op)
      2'd0: begin cfg_wr = 1'b1; cfg_id = id; cfg_en = val[0]; cfg_edge = val[1]; cfg_tgt = m[NCPU-1:0]; end
      2'd1: begin prio_wr = 1'b1; prio_id = id; prio_val = val; prio_cpu = m[0:0]; end
      2'd2: begin pend_set = 1'b1; pend_id = id; pend_mask = m[NCPU-1:0]; end
      default: begin pend_clr = 1'b1; pend_id = id; pend_mask = m[NCPU-1:0]; end
    endcase
    @(negedge clk);
    cfg_wr = 1'b0; prio_wr = 1'b0; pend_set = 1'b0; pend_clr = 1'b0;
  endtask

  // one more edge so the registered selection catches up
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    gbl_en = 1'b1; cpu_if_en = '1;
    cfg_wr = 0; cfg_id = 0; cfg_en = 0; cfg_edge = 0; cfg_tgt = 0;
    prio_wr = 0; prio_id = 0; prio_cpu = 0; prio_val = 0;
    pend_set = 0; pend_clr = 0; pend_id = 0; pend_mask = 0;
    ext_lvl = '0;
    pmask = {8'hFF, 8'hFF};
    run_prio = {9'h100, 9'h100};
    do_reset();

    chk("R1 reset", 0, 10'd1023, 1'b0);
    chk("R1 reset", 1, 10'd1023, 1'b0);

    for (int v = 0; v < 16; v++) begin
      apply(TBL[v].op, TBL[v].id, TBL[v].val, TBL[v].m);
      settle();
      chk($sformatf("R%0d vec%0d", TBL[v].rq, v), 0, TBL[v].e0, TBL[v].r0);
      chk($sformatf("R%0d vec%0d", TBL[v].rq, v), 1, TBL[v].e1, TBL[v].r1);
    end

    // R11: the output lags the state by one edge
    apply(2'd2, 10'd9, 8'h00, 8'h01);
    chk("R11 before", 0, 10'd1023, 1'b0);
    settle();
    chk("R11 after", 0, 10'd9, 1'b1);

    // R4: mask boundary (id9 has priority 0x3F on cpu0)
    @(negedge clk); pmask[7:0] = 8'h3E; @(negedge clk);
    chk("R4 masked", 0, 10'd1023, 1'b0);
    @(negedge clk); pmask[7:0] = 8'h3F; @(negedge clk);
    chk("R4 equal passes", 0, 10'd9, 1'b1);

    // R5: running priority boundary
    @(negedge clk); run_prio[8:0] = 9'h03F; @(negedge clk);
    chk("R5 equal no req", 0, 10'd9, 1'b0);
    @(negedge clk); run_prio[8:0] = 9'h040; @(negedge clk);
    chk("R5 preempt", 0, 10'd9, 1'b1);
    @(negedge clk); run_prio[8:0] = 9'h100; pmask[7:0] = 8'hFF; @(negedge clk);

    // R6: enables
    @(negedge clk); gbl_en = 1'b0; @(negedge clk);
    chk("R6 global off", 0, 10'd1023, 1'b0);
    @(negedge clk); gbl_en = 1'b1; cpu_if_en = 2'b10; @(negedge clk);
    chk("R6 cpu off", 0, 10'd1023, 1'b0);
    @(negedge clk); cpu_if_en = 2'b11; @(negedge clk);
    chk("R6 restored", 0, 10'd9, 1'b1);

    // R7: ext line 8 -> ID 40, enabled, level, target cpu1
    @(negedge clk); ext_lvl[8] = 1'b1; @(negedge clk); settle();
    chk("R7 rise id40", 1, 10'd40, 1'b1);
    chk("R7 cpu0 untouched", 0, 10'd9, 1'b1);
    @(negedge clk); ext_lvl[8] = 1'b0; @(negedge clk); settle();
    chk("R8 fall keeps pending", 1, 10'd40, 1'b1);
    apply(2'd3, 10'd40, 8'h00, 8'h02);
    settle();
    chk("R10 clear id40", 1, 10'd1023, 1'b0);

    // R7: edge-configured line raised while disabled, then enabled
    apply(2'd0, 10'd41, 8'h02, 8'h01);
    @(negedge clk); ext_lvl[9] = 1'b1; @(negedge clk); settle();
    chk("R7 hidden while disabled", 0, 10'd9, 1'b1);
    apply(2'd0, 10'd41, 8'h03, 8'h01);
    settle();
    chk("R7 edge latched", 0, 10'd41, 1'b1);
    apply(2'd3, 10'd41, 8'h00, 8'h01);
    settle();

    // R8: level-configured line raised while disabled stays not pending
    apply(2'd0, 10'd42, 8'h00, 8'h01);
    @(negedge clk); ext_lvl[10] = 1'b1; @(negedge clk); settle();
    apply(2'd0, 10'd42, 8'h01, 8'h01);
    settle();
    chk("R8 level ignored", 0, 10'd9, 1'b1);
    @(negedge clk); ext_lvl = '0; @(negedge clk);

    // R9: per-CPU bank vs shared priority
    apply(2'd2, 10'd9, 8'h00, 8'h02);
    settle();
    chk("R9 cpu1 id9", 1, 10'd9, 1'b1);
    @(negedge clk); pmask[15:8] = 8'h7F; @(negedge clk);
    chk("R9 cpu1 bank 0x80 masked", 1, 10'd1023, 1'b0);
    chk("R9 cpu0 bank 0x3F", 0, 10'd9, 1'b1);
    apply(2'd2, 10'd40, 8'h00, 8'h02);
    settle();
    chk("R9 shared 0x20", 1, 10'd40, 1'b1);
    apply(2'd1, 10'd40, 8'h90, 8'h01);
    settle();
    chk("R9 shared rewrite", 1, 10'd1023, 1'b0);
    @(negedge clk); pmask[15:8] = 8'hFF; @(negedge clk);
    chk("R9 cpu1 back to id9", 1, 10'd9, 1'b1);

    // R10: set and clear in one cycle -> clear wins
    @(negedge clk);
    pend_set = 1'b1; pend_clr = 1'b1; pend_id = 10'd9; pend_mask = 2'b01;
    @(negedge clk);
    pend_set = 1'b0; pend_clr = 1'b0;
    settle();
    chk("R10 clear wins", 0, 10'd1023, 1'b0);

    // R1: reset clears pending state
    do_reset();
    chk("R1 second reset", 1, 10'd1023, 1'b0);
    apply(2'd0, 10'd9, 8'h01, 8'h00);
    settle();
    chk("R1 pending cleared", 1, 10'd1023, 1'b0);
    chk("R1 pending cleared", 0, 10'd1023, 1'b0);

    done = 1;
    summary();
    $finish;
  end

endmodule